// File: doc/BRIEF.md
# Ethernet PHY RMII Mode Configuration Sequencer

This block sits beside a command-driven MDIO management controller. When it gets a start pulse, it runs a fixed register program through that controller so that a paged Ethernet PHY switches to RMII mode. The program has three writes:

- It opens vendor page 7 through the page-select register.
- It writes the RMII mode register on that page with the value needed when the reference clock is supplied externally.
- It returns the page-select register to page 0.

The basic mode control register is never addressed.

An optional read-back pass can be enabled by parameter. It opens page 7 again, reads the mode register, compares the result with the value that was written, and closes the page. A mismatch is reported as an error when the program finishes. The sequencer presents one command at a time on a valid/ready port. It takes read data back on a valid/ready return port. It holds each following command until the controller's busy flag has dropped.

The sequencer also supplies the controller's MDC prescale value. This value is computed from the system clock frequency so that MDC never exceeds 2.5 MHz. MDIO framing, start and turnaround bits, MDC generation and the pad tri-state all belong to the controller.

Top module: `phy_rmii_cfg_seq`

## Requirements
- R1: After a synchronous active-low reset, `done_o`, `error_o`, `cmd_valid_o` and `rd_ready_o` are low, and no command is presented until `start_i` is seen high.
- R2: `prescale_o` equals ceil(SYS_CLK_HZ / (2 × MDC_MAX_HZ)) − 1, clamped to 255. This gives 9 for a 50 MHz clock and a 2.5 MHz limit, so MDC = clk / (2 × (prescale + 1)).
- R3: Every command carries the PHY address parameter (default 0) and never register 0. Write commands use opcode 2'b01. The first three commands are, in this order: register 31 ← 16'h0007, register 16 ← 16'h7FFB, register 31 ← 16'h0000.
- R4: Once `cmd_valid_o` is high, it stays high with all command fields unchanged until a cycle in which `cmd_ready_i` is high.
- R5: A command is presented only after the previous one has been accepted and `mgmt_busy_i` has been seen low. `cmd_valid_o` rises only in a cycle that follows a low `mgmt_busy_i`.
- R6: With VERIFY = 1, three more commands follow the writes, in this order: register 31 ← 16'h0007, a read of register 16 with opcode 2'b10, and register 31 ← 16'h0000. `rd_ready_o` is high only while the read result is awaited.
- R7: When the program finishes, `error_o` goes high together with `done_o` if the value read back differs from 16'h7FFB. Otherwise `error_o` stays low.
- R8: `done_o` rises after the last command completes and stays high, with no command presented, until the next `start_i`.
- R9: A `start_i` pulse while `done_o` is high clears `done_o` and `error_o` on the next clock edge and re-runs the whole program from the first command.
- R10: `start_i` pulses while a program is running are ignored: no command is added or repeated.
- R11: Asserting reset in the middle of a program returns the sequencer to idle with `done_o` and `error_o` low. A later start runs the full program from the first command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start (or restart) the register program |
| cmd_valid_o | output | 1 | Command presented to the management controller |
| cmd_ready_i | input | 1 | Controller accepts the command |
| cmd_phy_o | output | 5 | PHY address of the command |
| cmd_reg_o | output | 5 | Register address of the command |
| cmd_data_o | output | 16 | Write data of the command |
| cmd_op_o | output | 2 | Opcode: 2'b01 write, 2'b10 read |
| mgmt_busy_i | input | 1 | Controller is shifting a frame |
| rd_data_i | input | 16 | Read result from the controller |
| rd_valid_i | input | 1 | Read result valid |
| rd_ready_o | output | 1 | Sequencer is waiting for a read result |
| prescale_o | output | 8 | MDC prescale value for the controller |
| done_o | output | 1 | Program finished (sticky until restart) |
| error_o | output | 1 | Read-back mismatch on the finished program |

## Verification
The assertions assume three things about the controller.
- `mgmt_busy_i` rises on the clock edge that accepts a command and stays high until any read result has been handed over.
- `cmd_ready_i` is never high while the controller is busy.
- Read data arrives only after a read has been accepted.

The bench's controller model follows these rules by construction. It derives `cmd_ready_i` from its own busy flag gated by a stall pattern, holds busy for a per-run latency, and raises `rd_valid_i` only for an accepted read. Start pulses are one cycle long and are applied at idle, while a program is running, and while done is high.

// File: rtl/phy_cfg_pkg.sv
// Package: shared command type, opcodes and register constants for the
// PHY RMII configuration sequencer.
package phy_cfg_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int OP_W   = 2;

    localparam logic [OP_W-1:0]   OP_WRITE = 2'b01;
    localparam logic [OP_W-1:0]   OP_READ  = 2'b10;

    localparam logic [ADDR_W-1:0] REG_PAGE_SEL = 5'd31;
    localparam logic [ADDR_W-1:0] REG_RMII_MODE = 5'd16;

    localparam logic [DATA_W-1:0] PAGE_RMII    = 16'h0007;
    localparam logic [DATA_W-1:0] PAGE_DEFAULT = 16'h0000;
    localparam logic [DATA_W-1:0] RMII_EXT_CLK = 16'h7FFB;

    typedef struct packed {
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] data;
        logic [OP_W-1:0]   op;
    } mgmt_cmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GATE,
        SQ_ISSUE,
        SQ_READ,
        SQ_SETTLE,
        SQ_DRAIN
    } seq_state_t;

endpackage

// File: rtl/phy_cfg_steps.sv
// Step table: maps a step index to the register command for that step.
// Steps 0..2 are the mandatory page-open / mode-write / page-close writes;
// steps 3..5 are the read-back pass. Assumes the caller never indexes past
// the last enabled step.
module phy_cfg_steps
    import phy_cfg_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic [STEP_W-1:0] step_i,
    output mgmt_cmd_t         cmd_o
);

    // Decode the step index into a register command.
    always_comb begin
        case (step_i)
            STEP_W'(0): cmd_o = '{REG_PAGE_SEL,  PAGE_RMII,    OP_WRITE};
            STEP_W'(1): cmd_o = '{REG_RMII_MODE, RMII_EXT_CLK, OP_WRITE};
            STEP_W'(2): cmd_o = '{REG_PAGE_SEL,  PAGE_DEFAULT, OP_WRITE};
            STEP_W'(3): cmd_o = '{REG_PAGE_SEL,  PAGE_RMII,    OP_WRITE};
            STEP_W'(4): cmd_o = '{REG_RMII_MODE, 16'h0000,     OP_READ};
            default:    cmd_o = '{REG_PAGE_SEL,  PAGE_DEFAULT, OP_WRITE};
        endcase
    end

endmodule

// File: rtl/phy_cfg_readback.sv
// Read-back comparator: flags a difference between returned register data
// and the expected mode value on the bits selected by MASK.
module phy_cfg_readback
    import phy_cfg_pkg::*;
#(
    parameter logic [DATA_W-1:0] EXPECT = RMII_EXT_CLK,
    parameter logic [DATA_W-1:0] MASK   = 16'hFFFF
) (
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              mismatch_o
);

    // Masked inequality against the expected value.
    always_comb mismatch_o = ((rd_data_i ^ EXPECT) & MASK) != '0;

endmodule

// File: rtl/phy_rmii_cfg_seq.sv
// Top: runs the fixed RMII register program through an MDIO management
// controller. Assumes the controller raises busy on the accepting edge and
// keeps it high until any read result has been handed back.
module phy_rmii_cfg_seq
    import phy_cfg_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR   = 5'd0,
    parameter bit         VERIFY     = 1'b1,
    parameter int         SYS_CLK_HZ = 50_000_000,
    parameter int         MDC_MAX_HZ = 2_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        cmd_valid_o,
    input  logic        cmd_ready_i,
    output logic [4:0]  cmd_phy_o,
    output logic [4:0]  cmd_reg_o,
    output logic [15:0] cmd_data_o,
    output logic [1:0]  cmd_op_o,
    input  logic        mgmt_busy_i,
    input  logic [15:0] rd_data_i,
    input  logic        rd_valid_i,
    output logic        rd_ready_o,
    output logic [7:0]  prescale_o,
    output logic        done_o,
    output logic        error_o
);

    localparam int STEP_W    = 3;
    localparam int NSTEPS    = VERIFY ? 6 : 3;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEPS - 1);
    localparam int DIV2      = 2 * MDC_MAX_HZ;
    localparam int PRESC_RAW = (SYS_CLK_HZ + DIV2 - 1) / DIV2 - 1;
    localparam int PRESC     = (PRESC_RAW > 255) ? 255 : ((PRESC_RAW < 0) ? 0 : PRESC_RAW);

    seq_state_t        state_q;
    logic [STEP_W-1:0] step_q;
    logic              done_q;
    logic              err_q;
    logic              miss_q;
    logic              mismatch;
    mgmt_cmd_t         cur_cmd;

    phy_cfg_steps #(.STEP_W(STEP_W)) u_steps (
        .step_i (step_q),
        .cmd_o  (cur_cmd)
    );

    generate
        if (VERIFY) begin : g_verify
            phy_cfg_readback #(.EXPECT(RMII_EXT_CLK), .MASK(16'hFFFF)) u_cmp (
                .rd_data_i  (rd_data_i),
                .mismatch_o (mismatch)
            );
        end else begin : g_no_verify
            logic unused_rd;
            assign unused_rd  = ^rd_data_i;
            assign mismatch   = 1'b0;
        end
    endgenerate

    // Sequencer: gate on busy, issue, wait for read data, drain, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            step_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            miss_q  <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        step_q  <= '0;
                        done_q  <= 1'b0;
                        err_q   <= 1'b0;
                        miss_q  <= 1'b0;
                        state_q <= SQ_GATE;
                    end
                end
                SQ_GATE: begin
                    if (!mgmt_busy_i) state_q <= SQ_ISSUE;
                end
                SQ_ISSUE: begin
                    if (cmd_ready_i)
                        state_q <= (cur_cmd.op == OP_READ) ? SQ_READ : SQ_SETTLE;
                end
                SQ_READ: begin
                    if (rd_valid_i) begin
                        miss_q  <= miss_q | mismatch;
                        state_q <= SQ_SETTLE;
                    end
                end
                SQ_SETTLE: state_q <= SQ_DRAIN;
                SQ_DRAIN: begin
                    if (!mgmt_busy_i) begin
                        if (step_q == LAST_STEP) begin
                            done_q  <= 1'b1;
                            err_q   <= miss_q;
                            state_q <= SQ_IDLE;
                        end else begin
                            step_q  <= step_q + 1'b1;
                            state_q <= SQ_ISSUE;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Port drive: command fields come straight from the step table.
    always_comb begin
        cmd_valid_o = (state_q == SQ_ISSUE);
        cmd_phy_o   = PHY_ADDR;
        cmd_reg_o   = cur_cmd.regad;
        cmd_data_o  = cur_cmd.data;
        cmd_op_o    = cur_cmd.op;
        rd_ready_o  = (state_q == SQ_READ);
        prescale_o  = 8'(PRESC);
        done_o      = done_q;
        error_o     = err_q;
    end

endmodule

// File: rtl/phy_rmii_cfg_seq_chk.sv
// Checker: port-level properties of the configuration sequencer, bound to
// every instance of the top. Assumes the controller protocol in the brief.
module phy_rmii_cfg_seq_chk #(
    parameter logic [4:0] PHY_ADDR = 5'd0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        cmd_valid_o,
    input logic        cmd_ready_i,
    input logic [4:0]  cmd_phy_o,
    input logic [4:0]  cmd_reg_o,
    input logic [15:0] cmd_data_o,
    input logic [1:0]  cmd_op_o,
    input logic        mgmt_busy_i,
    input logic        rd_ready_o,
    input logic        done_o,
    input logic        error_o
);

    // R1: no command and no read wait while done is reported
    p_quiet_when_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cmd_valid_o && !rd_ready_o));

    // R3: fixed PHY address, never register 0
    p_phy_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_phy_o == PHY_ADDR && cmd_reg_o != 5'd0));

    // R3/R6: writes use 01, the only read is register 16 with 10
    p_opcode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_op_o == 2'b01 || (cmd_op_o == 2'b10 && cmd_reg_o == 5'd16)));

    // R4: command held stable until accepted
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_reg_o) && $stable(cmd_data_o) && $stable(cmd_op_o)));

    // R5: a new command appears only after busy was seen low
    p_gate_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid_o) |-> !$past(mgmt_busy_i));

    // R7: error is only reported alongside done
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

    // R8: done is sticky until a start pulse
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

endmodule

bind phy_rmii_cfg_seq phy_rmii_cfg_seq_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (.*);

// File: tb/phy_rmii_cfg_seq_tb_top.sv
// Bench: controller model plus scoreboard of expected commands.
module phy_rmii_cfg_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cmd_valid_o, cmd_ready_i;
    logic [4:0]  cmd_phy_o, cmd_reg_o;
    logic [15:0] cmd_data_o;
    logic [1:0]  cmd_op_o;
    logic        mgmt_busy_i;
    logic [15:0] rd_data_i;
    logic        rd_valid_i, rd_ready_o;
    logic [7:0]  prescale_o;
    logic        done_o, error_o;

    int n_chk = 0;
    int n_bad = 0;
    int n_acc = 0;
    int n_proto = 0;

    logic [27:0] exp_q[$];

    // controller model knobs
    int          lat = 2;
    bit          stall = 1'b0;
    logic [15:0] rd_value = 16'h7FFB;
    logic [3:0]  stall_ctr = '0;
    int          cnt = 0;
    logic        pend = 1'b0;

    always #10 clk = ~clk;

    phy_rmii_cfg_seq dut_i (.*);

    assign cmd_ready_i = !mgmt_busy_i && (!stall || stall_ctr[1:0] == 2'd3);
    assign rd_data_i   = rd_value;

    // Controller model: busy for lat cycles, then a read result if needed.
    always @(posedge clk) begin
        stall_ctr <= stall_ctr + 1'b1;
        if (!rst_n) begin
            mgmt_busy_i <= 1'b0; rd_valid_i <= 1'b0; pend <= 1'b0; cnt <= 0;
        end else if (cmd_valid_o && cmd_ready_i) begin
            mgmt_busy_i <= 1'b1; cnt <= lat; pend <= (cmd_op_o == 2'b10);
        end else if (mgmt_busy_i) begin
            if (cnt != 0) cnt <= cnt - 1;
            else if (pend) begin
                if (rd_valid_i && rd_ready_o) begin
                    rd_valid_i <= 1'b0; pend <= 1'b0; mgmt_busy_i <= 1'b0;
                end else rd_valid_i <= 1'b1;
            end else mgmt_busy_i <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver side: push one expected command
    task automatic push(input logic [4:0] r, input logic [15:0] d, input logic [1:0] op);
        exp_q.push_back({5'd0, r, d, op});
    endtask

    task automatic push_program();
        push(5'd31, 16'h0007, 2'b01);  // R3
        push(5'd16, 16'h7FFB, 2'b01);  // R3
        push(5'd31, 16'h0000, 2'b01);  // R3
        push(5'd31, 16'h0007, 2'b01);  // R6
        push(5'd16, 16'h0000, 2'b10);  // R6 read
        push(5'd31, 16'h0000, 2'b01);  // R6
    endtask

    // Monitor: compare accepted commands, watch hold and busy protocol.
    logic        prev_stall_v = 1'b0;
    logic [22:0] prev_fields = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall_v && !(cmd_valid_o && {cmd_reg_o, cmd_data_o, cmd_op_o} == prev_fields))
                n_proto++;  // R4 violation
            if (cmd_valid_o && mgmt_busy_i) n_proto++;  // R5 violation
            if (rd_ready_o && cmd_valid_o) n_proto++;   // R6 violation
            if (cmd_valid_o && cmd_ready_i) begin
                n_acc++;
                if (exp_q.size() == 0)
                    chk(1'b0, "R10 unexpected command", {cmd_phy_o, cmd_reg_o, cmd_data_o, cmd_op_o}, 0);
                else begin
                    logic [27:0] e;
                    logic [27:0] a;
                    e = exp_q.pop_front();
                    a = {cmd_phy_o, cmd_reg_o, (cmd_op_o == 2'b10) ? 16'h0000 : cmd_data_o, cmd_op_o};
                    chk(a == e, "R3/R6 command order", a, e);
                end
            end
            prev_stall_v <= cmd_valid_o && !cmd_ready_i;
            prev_fields  <= {cmd_reg_o, cmd_data_o, cmd_op_o};
        end else prev_stall_v <= 1'b0;
    end

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done_o; i++) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R2 prescale
        chk(!done_o && !error_o, "R1 done/error after reset", {done_o, error_o}, 0);
        chk(!cmd_valid_o && !rd_ready_o, "R1 idle ports", {cmd_valid_o, rd_ready_o}, 0);
        chk(prescale_o == 8'd9, "R2 prescale", prescale_o, 9);
        repeat (20) @(negedge clk);
        chk(n_acc == 0, "R1 no command before start", n_acc, 0);

        // Run 1: matching read-back, extra start mid-run (R10)
        push_program();
        pulse_start();
        while (n_acc < 2) @(negedge clk);
        pulse_start();
        wait_done();
        chk(done_o, "R8 done after program", done_o, 1);
        chk(!error_o, "R7 no error on match", error_o, 0);
        chk(n_acc == 6, "R10 command count", n_acc, 6);
        chk(exp_q.size() == 0, "R6 all commands seen", exp_q.size(), 0);
        repeat (30) @(negedge clk);
        chk(done_o && n_acc == 6, "R8 done sticky and quiet", {done_o, n_acc[7:0]}, {1'b1, 8'd6});

        // Run 2: restart while done, stalls, long latency, mismatch (R9, R7)
        lat = 7; stall = 1'b1; rd_value = 16'h7FFA;
        push_program();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(!done_o, "R9 done cleared by restart", done_o, 0);
        wait_done();
        chk(done_o && error_o, "R7 error on mismatch", {done_o, error_o}, 2'b11);
        chk(exp_q.size() == 0, "R9 full rerun", exp_q.size(), 0);

        // Run 3: restart clears error; short latency, match
        lat = 0; stall = 1'b0; rd_value = 16'h7FFB;
        push_program();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(!error_o && !done_o, "R9 error cleared by restart", {done_o, error_o}, 0);
        wait_done();
        chk(done_o && !error_o, "R7 match after mismatch", {done_o, error_o}, 2'b10);

        // Run 4: reset in mid-program (R11)
        n_acc = 0; lat = 3;
        push_program();
        pulse_start();
        while (n_acc < 2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!done_o && !error_o && !cmd_valid_o, "R11 idle during reset",
            {done_o, error_o, cmd_valid_o}, 0);
        rst_n = 1'b1;
        exp_q.delete();
        n_acc = 0;
        repeat (10) @(negedge clk);
        chk(n_acc == 0 && !done_o, "R11 idle after reset", n_acc, 0);
        push_program();
        pulse_start();
        wait_done();
        chk(done_o && n_acc == 6 && exp_q.size() == 0, "R11 full program after reset", n_acc, 6);

        chk(n_proto == 0, "R4/R5 handshake protocol", n_proto, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule